// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt Controller

This block lets any core in a small multiprocessor raise an interrupt on another core and hand it a 16-bit message. Each core has two 32-bit words, a control word and a status word, at its own 8-byte slot in a small register space. Each core drives one interrupt line. A core sends a message by writing its own control word with the generate bit set. The destination index and the payload travel in that same word. The receiving core's status word then records the sender's index and the payload, and its interrupt line goes high. The receiver clears its pending flag, and with it the interrupt line, by writing its own control word with the acknowledge bit set.

The register bus is minimal: an address, a write strobe, write data and combinational read data. Address bit 2 selects the word (0 control, 1 status). The bits from bit 3 upward give the core index. The number of cores is a parameter of at most 4. The address width leaves room for indices above that count, and accesses to those indices have no effect.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset, every control and status word reads as zero and every interrupt line is low.
- R2: A write to a core's control word (address bit 2 = 0, core index in the address bits from bit 3 upward) stores the full 32-bit word, and a read of that address returns it. The exception is the case given in R8.
- R3: A control write by core S with bit 30 (generate) set and bits 29:16 naming a valid destination D sets D's status word to: bit 31 zero, bit 30 one (pending), bits 29:16 equal to S, and bits 15:0 equal to bits 15:0 of the written word.
- R4: The destination's interrupt line is a registered level. It goes high on the first clock edge after the generating write.
- R5: A control write with bit 31 (acknowledge) set clears bit 30 of the writer's own status word and drops its own interrupt line after one clock edge. The other status bits are kept.
- R6: When one write sets both generate and acknowledge, the generate is applied first. A core that targets itself with both bits set ends with the new sender and payload in its status word, its pending bit clear and its interrupt line low.
- R7: Writes to any status address (address bit 2 = 1) change no register and no interrupt line.
- R8: A control write with generate set and a destination index at or above the core count is dropped entirely. The control word, all status words and all interrupt lines stay unchanged, even when acknowledge is also set.
- R9: Any access whose core index is at or above the core count is ignored: writes change nothing and reads return zero.
- R10: A write alters the interrupt line and status only of its destination core and of the writing core. All other cores keep their state.
- R11: A generate to a core whose interrupt is already pending overwrites its status word, so the most recent sender and payload are kept and the line stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address: bit 2 selects the word, bits from bit 3 upward give the core index |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed word, combinational |
| irq | output | NCORE | One level interrupt line per core |

## Verification
A single control write can both raise an interrupt on a destination and acknowledge the writer's own pending interrupt. When the destination is the writer itself, the two actions land on the same status bit in the same cycle. The bench provokes this by sweeping every sender and destination pair, including each core sending to itself with both bits set. It also sends to one core while that core acknowledges. After each write it reads back every status word and samples every interrupt line. Each result is compared with a model in which the generate is applied first and the acknowledge second, so for a self-targeted write the pending bit must come out clear while the new sender and payload are kept.

// File: rtl/ipi_ctrl.sv
module ipi_ctrl #(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [NCORE-1:0]  irq
);
  localparam int IDX_W = ADDR_W - 3;
  localparam logic [IDX_W:0] NC_IDX = (IDX_W+1)'(NCORE);
  localparam logic [14:0]    NC_DST = 15'(NCORE);

  logic [31:0] ctrl_q [NCORE];
  logic [31:0] stat_q [NCORE];

  wire [IDX_W-1:0] idx      = addr[ADDR_W-1:3];
  wire             sel_stat = addr[2];
  wire             idx_ok   = {1'b0, idx} < NC_IDX;
  wire [13:0]      dst      = wr_data[29:16];
  wire             gen      = wr_data[30];
  wire             ack      = wr_data[31];
  wire             dst_ok   = {1'b0, dst} < NC_DST;
  wire             take     = wr_en & ~sel_stat & idx_ok & (~gen | dst_ok);
  wire [13:0]      src14    = {{(14-IDX_W){1'b0}}, idx};

  logic unused_lo;
  assign unused_lo = ^addr[1:0];

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    localparam logic [IDX_W-1:0] ME_IDX = IDX_W'(i);
    localparam logic [13:0]      ME_DST = 14'(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[i] <= '0;
        stat_q[i] <= '0;
      end else if (take) begin
        if (idx == ME_IDX) ctrl_q[i] <= wr_data;
        if (gen && dst == ME_DST) stat_q[i] <= {2'b01, src14, wr_data[15:0]};
        if (ack && idx == ME_IDX) stat_q[i][30] <= 1'b0;
      end
    end

    assign irq[i] = stat_q[i][30];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCORE; i++)
      if (idx_ok && idx == IDX_W'(i))
        rd_data = sel_stat ? stat_q[i] : ctrl_q[i];
  end
endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk #(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [NCORE-1:0]  irq
);
  localparam int IDX_W = ADDR_W - 3;
  localparam logic [IDX_W:0] NC_IDX = (IDX_W+1)'(NCORE);
  localparam logic [14:0]    NC_DST = 15'(NCORE);

  wire [IDX_W-1:0] idx    = addr[ADDR_W-1:3];
  wire             ctl_wr = wr_en && !addr[2] && ({1'b0, idx} < NC_IDX);
  wire             dst_ok = {1'b0, wr_data[29:16]} < NC_DST;
  wire             valid  = ctl_wr && (!wr_data[30] || dst_ok);

  logic [NCORE-1:0] hit_g, hit_a;
  always_comb begin
    for (int i = 0; i < NCORE; i++) begin
      hit_g[i] = valid && wr_data[30] && wr_data[29:16] == 14'(i);
      hit_a[i] = valid && wr_data[31] && idx == IDX_W'(i);
    end
  end

  // R4
  gen_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(hit_g & ~hit_a) |=> (irq & $past(hit_g & ~hit_a)) == $past(hit_g & ~hit_a));
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |hit_a |=> (irq & $past(hit_a)) == '0);
  // R10
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq)) & ~$past(hit_g)) == '0);
  // R10
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq & $past(irq)) & ~$past(hit_a)) == '0);
  // R7
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[2]) |=> $stable(irq));
  // R8
  bad_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[30] && !dst_ok) |=> $stable(irq));
endmodule

bind ipi_ctrl ipi_ctrl_chk #(.NCORE(NCORE), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .irq(irq)
);

// File: tb/ipi_ctrl_test.sv
module ipi_ctrl_test;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NC-1:0] irq;

  int total = 0;
  int bad = 0;
  logic [31:0] m_ctrl [NC];
  logic [31:0] m_stat [NC];

  ipi_ctrl #(.NCORE(NC), .ADDR_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [5:0] ca(int c, bit st);
    return {c[2:0], st, 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(logic [5:0] a, logic [31:0] d);
    int s = int'(a[5:3]);
    int t = int'(d[29:16]);
    if (a[2] == 1'b0 && s < NC && (!d[30] || t < NC)) begin
      m_ctrl[s] = d;
      if (d[30]) m_stat[t] = {2'b01, 11'd0, a[5:3], d[15:0]};
      if (d[31]) m_stat[s][30] = 1'b0;
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model(a, d);
  endtask

  task automatic verify(string tag);
    logic [NC-1:0] exp_irq;
    for (int i = 0; i < NC; i++) begin
      addr = ca(i, 1'b0); #1;
      chk({tag, " ctrl"}, rd_data, m_ctrl[i]);
      addr = ca(i, 1'b1); #1;
      chk({tag, " stat"}, rd_data, m_stat[i]);
      exp_irq[i] = m_stat[i][30];
    end
    for (int i = NC; i < 8; i++) begin
      addr = ca(i, 1'b0); #1;
      chk("R9 read ctrl", rd_data, 32'h0);
      addr = ca(i, 1'b1); #1;
      chk("R9 read stat", rd_data, 32'h0);
    end
    chk({tag, " irq"}, 32'(irq), 32'(exp_irq));
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin m_ctrl[i] = '0; m_stat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    verify("R1");

    for (int i = 0; i < NC; i++) wr(ca(i, 0), 32'h0000_A5A0 + 32'(i));
    verify("R2");
    wr(ca(2, 0), 32'h8123_4567);
    verify("R2 ack-only");

    for (int s = 0; s < NC; s++)
      for (int d = 0; d < NC; d++) begin
        wr(ca(s, 0), {2'b01, 14'(d), 16'h1200 + 16'(s * 16 + d)});
        verify("R3,R10");
        chk("R4 irq dest", 32'(irq[d]), 32'd1);
        wr(ca(d, 0), 32'h8000_0000);
        verify("R5");
        chk("R5 irq dest", 32'(irq[d]), 32'd0);
      end

    wr(ca(0, 0), {2'b01, 14'd2, 16'h1111});
    wr(ca(3, 0), {2'b01, 14'd2, 16'h3333});
    verify("R11");
    chk("R11 irq", 32'(irq[2]), 32'd1);

    for (int s = 0; s < NC; s++) begin
      wr(ca(s, 0), {2'b01, 14'(s), 16'h5500 + 16'(s)});
      wr(ca(s, 0), {2'b11, 14'(s), 16'hBE00 + 16'(s)});
      verify("R6");
      chk("R6 self irq", 32'(irq[s]), 32'd0);
    end
    wr(ca(1, 0), {2'b01, 14'd0, 16'h0A0A});
    wr(ca(0, 0), {2'b11, 14'd3, 16'h0B0B});
    verify("R6 cross");

    for (int i = 0; i < NC; i++) wr(ca(i, 1), 32'hFFFF_FFFF);
    verify("R7");

    wr(ca(1, 0), {2'b01, 14'd4, 16'h7777});
    wr(ca(2, 0), {2'b11, 14'd3, 16'hCCCC});
    wr(ca(2, 0), {2'b11, 14'd5, 16'h8888});
    wr(ca(0, 0), {2'b01, 14'h3FFF, 16'h9999});
    verify("R8");

    for (int i = NC; i < 8; i++) begin
      wr(ca(i, 0), {2'b01, 14'd1, 16'hDEAD});
      wr(ca(i, 0), 32'h8000_0000);
      wr(ca(i, 1), 32'h4000_FFFF);
    end
    verify("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule